// File: doc/BRIEF.md
# Condition-Field Two-Input Lookup Update Unit

This unit owns a 32-bit condition register split into eight 4-bit fields. It runs a bitwise two-input logic operation whose truth table is read at run time. An operation names three fields: a target field, a second operand field and a table field. For each of the target's four bits, the target bit and the matching operand bit together form a 2-bit index. That index selects one of the four bits in the table field. A 4-bit write mask decides which target bits take the new value. The other target bits keep their old value. A mask of all zeros does not update anything and raises an illegal-instruction trap.

The surrounding pipeline can also overwrite the whole register through a write port. The current register value is always visible on an output. An operation takes effect at the clock edge where it is sampled. The result, and any trap pulse, appear in the following cycle.

Top module: `cflut_update_unit`

## Requirements
- R1: A synchronous active-high reset clears the condition register to zero and drives `trap_o` low.
- R2: Field n, for n from 0 to 7, occupies `creg_o[31-4n : 28-4n]`. Field 0 is therefore the top nibble. Inside a field slice, bit position k (3 down to 0) of the 4-bit slice is the k-th bit of that slice.
- R3: For each slice position k of the target field, the index is {target[k], operand[k]}, with the target bit as the high index bit. The new value is table[index], where table[0] is the least significant bit of the table field's slice.
- R4: Target slice position k is written only when `op_mask_i[k]` is 1. Otherwise it keeps its previous value.
- R5: An operation changes no field other than the target field.
- R6: An operation with `op_mask_i` equal to 4'b0000 leaves the whole register unchanged. It sets `trap_o` high for exactly the one following cycle.
- R7: `trap_o` stays low after any cycle without a zero-mask operation.
- R8: All four new bits are computed from the register value before the update. This holds even when the target, operand and table fields are the same field or overlap.
- R9: With no operation and no write, the register holds its value.
- R10: When `wr_en_i` is high, the register takes `wr_data_i` at that edge. Any operation in the same cycle is dropped, and it raises no trap.
- R11: The result of an operation is visible on `creg_o` in the cycle right after the edge that sampled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation strobe, one operation per cycle |
| op_tgt_i | input | 3 | Target field number (read and written) |
| op_src_i | input | 3 | Operand field number |
| op_tab_i | input | 3 | Table field number |
| op_mask_i | input | 4 | Per-bit write mask, aligned to field slice positions |
| wr_en_i | input | 1 | Whole-register write enable |
| wr_data_i | input | 32 | Whole-register write data |
| creg_o | output | 32 | Current condition register value |
| trap_o | output | 1 | Illegal-instruction pulse for a zero-mask operation |

## Verification
The assertions assume the field numbers, mask and write data are known (not X) whenever their strobe is high. They also assume reset is held for at least one edge before the first operation. The stimulus drives every input from defined values on the falling edge and holds reset over several edges. It preloads the register through the write port before each operation, so every operand, table and mask combination, including fully aliased fields, starts from a known value.

// File: rtl/cflut_pkg.sv
package cflut_pkg;
  localparam int CFL_FIELD_W    = 4;
  localparam int CFL_NUM_FIELDS = 8;
  localparam int CFL_LUT_IDX_W  = 2;
  localparam int CFL_LUT_SIZE   = 1 << CFL_LUT_IDX_W;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_APPLY = 2'd2,
    ACT_TRAP  = 2'd3
  } cfl_action_e;
endpackage

// File: rtl/cflut_field_pick.sv
module cflut_field_pick #(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 8,
  localparam int REG_W     = FIELD_W * NUM_FIELDS,
  localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic [REG_W-1:0]   reg_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [FIELD_W-1:0] field_o
);
  logic [FIELD_W-1:0] slices [NUM_FIELDS];

  genvar n;
  generate
    for (n = 0; n < NUM_FIELDS; n++) begin : g_slice
      assign slices[n] = reg_i[REG_W-1-FIELD_W*n -: FIELD_W];
    end
  endgenerate

  assign field_o = slices[sel_i];
endmodule

// File: rtl/cflut_lut_eval.sv
module cflut_lut_eval
  import cflut_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] tgt_i,
  input  logic [FIELD_W-1:0] src_i,
  input  logic [FIELD_W-1:0] tab_i,
  input  logic [FIELD_W-1:0] mask_i,
  output logic [FIELD_W-1:0] field_o
);
  logic [CFL_LUT_SIZE-1:0] table_bits;
  assign table_bits = tab_i[CFL_LUT_SIZE-1:0];

  genvar k;
  generate
    for (k = 0; k < FIELD_W; k++) begin : g_bit
      logic [CFL_LUT_IDX_W-1:0] idx;
      logic                     pick;
      assign idx        = {tgt_i[k], src_i[k]};
      assign pick       = table_bits[idx];
      assign field_o[k] = mask_i[k] ? pick : tgt_i[k];
    end
  endgenerate
endmodule

// File: rtl/cflut_field_merge.sv
module cflut_field_merge #(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 8,
  localparam int REG_W     = FIELD_W * NUM_FIELDS,
  localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic [REG_W-1:0]   reg_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [REG_W-1:0]   reg_o
);
  genvar n;
  generate
    for (n = 0; n < NUM_FIELDS; n++) begin : g_place
      localparam logic [SEL_W-1:0] IDX = SEL_W'(n);
      assign reg_o[REG_W-1-FIELD_W*n -: FIELD_W] =
        (sel_i == IDX) ? field_i : reg_i[REG_W-1-FIELD_W*n -: FIELD_W];
    end
  endgenerate
endmodule

// File: rtl/cflut_update_unit.sv
module cflut_update_unit
  import cflut_pkg::*;
#(
  parameter int FIELD_W    = CFL_FIELD_W,
  parameter int NUM_FIELDS = CFL_NUM_FIELDS,
  localparam int REG_W     = FIELD_W * NUM_FIELDS,
  localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid_i,
  input  logic [SEL_W-1:0]   op_tgt_i,
  input  logic [SEL_W-1:0]   op_src_i,
  input  logic [SEL_W-1:0]   op_tab_i,
  input  logic [FIELD_W-1:0] op_mask_i,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   creg_o,
  output logic               trap_o
);
  logic [REG_W-1:0]   creg_q;
  logic               trap_q;
  logic [FIELD_W-1:0] tgt_f, src_f, tab_f, new_f;
  logic [REG_W-1:0]   merged;
  cfl_action_e        action;

  // All reads come from the pre-update register, so aliasing is harmless.
  cflut_field_pick #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_pick_tgt (
    .reg_i(creg_q), .sel_i(op_tgt_i), .field_o(tgt_f));
  cflut_field_pick #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_pick_src (
    .reg_i(creg_q), .sel_i(op_src_i), .field_o(src_f));
  cflut_field_pick #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_pick_tab (
    .reg_i(creg_q), .sel_i(op_tab_i), .field_o(tab_f));

  cflut_lut_eval #(.FIELD_W(FIELD_W)) u_eval (
    .tgt_i(tgt_f), .src_i(src_f), .tab_i(tab_f),
    .mask_i(op_mask_i), .field_o(new_f));

  cflut_field_merge #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) u_merge (
    .reg_i(creg_q), .sel_i(op_tgt_i), .field_i(new_f), .reg_o(merged));

  always_comb begin
    if (wr_en_i)                  action = ACT_WRITE;
    else if (!op_valid_i)         action = ACT_IDLE;
    else if (op_mask_i == '0)     action = ACT_TRAP;
    else                          action = ACT_APPLY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      creg_q <= '0;
      trap_q <= 1'b0;
    end else begin
      trap_q <= (action == ACT_TRAP);
      case (action)
        ACT_WRITE: creg_q <= wr_data_i;
        ACT_APPLY: creg_q <= merged;
        default:   creg_q <= creg_q;
      endcase
    end
  end

  assign creg_o = creg_q;
  assign trap_o = trap_q;
endmodule

// File: rtl/cflut_update_chk.sv
module cflut_update_chk #(
  parameter int FIELD_W    = 4,
  parameter int NUM_FIELDS = 8,
  localparam int REG_W     = FIELD_W * NUM_FIELDS,
  localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
  input logic               clk,
  input logic               rst,
  input logic               op_valid_i,
  input logic [SEL_W-1:0]   op_tgt_i,
  input logic [FIELD_W-1:0] op_mask_i,
  input logic               wr_en_i,
  input logic [REG_W-1:0]   wr_data_i,
  input logic [REG_W-1:0]   creg_o,
  input logic               trap_o
);
  function automatic logic [FIELD_W-1:0] slice_of(input logic [REG_W-1:0] r,
                                                  input logic [SEL_W-1:0] n);
    return FIELD_W'(r >> (REG_W - FIELD_W * (int'(n) + 1)));
  endfunction

  logic zero_op;
  assign zero_op = op_valid_i && !wr_en_i && (op_mask_i == '0);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (creg_o == '0 && !trap_o));

  // R6
  zero_mask_trap_chk: assert property (@(posedge clk) disable iff (rst)
    zero_op |=> (trap_o && creg_o == $past(creg_o)));

  // R7
  no_spurious_trap_chk: assert property (@(posedge clk) disable iff (rst)
    !zero_op |=> !trap_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid_i && !wr_en_i) |=> $stable(creg_o));

  // R10
  write_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> creg_o == $past(wr_data_i));

  // R4
  masked_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !wr_en_i) |=>
      (((slice_of(creg_o, $past(op_tgt_i)) ^ slice_of($past(creg_o), $past(op_tgt_i)))
        & ~$past(op_mask_i)) == '0));

  genvar n;
  generate
    for (n = 0; n < NUM_FIELDS; n++) begin : g_other
      localparam logic [SEL_W-1:0] IDX = SEL_W'(n);
      // R5
      other_field_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && !wr_en_i && op_tgt_i != IDX) |=>
          (slice_of(creg_o, IDX) == slice_of($past(creg_o), IDX)));
    end
  endgenerate
endmodule

bind cflut_update_unit cflut_update_chk #(
  .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)
) u_chk (
  .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_tgt_i(op_tgt_i),
  .op_mask_i(op_mask_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .creg_o(creg_o), .trap_o(trap_o)
);

// File: tb/sim_cflut_update_unit.sv
`timescale 1ns/1ps
module sim_cflut_update_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_tgt_i = '0, op_src_i = '0, op_tab_i = '0;
  logic [3:0]  op_mask_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] creg_o;
  logic        trap_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cflut_update_unit u0 (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_tgt_i(op_tgt_i),
    .op_src_i(op_src_i), .op_tab_i(op_tab_i), .op_mask_i(op_mask_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .creg_o(creg_o), .trap_o(trap_o));

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: bit numbering MSB-0 across the 32-bit register (R2, R3, R4).
  function automatic logic [31:0] model(input logic [31:0] r, input int t, input int s,
                                        input int b, input logic [3:0] m);
    logic [31:0] res = r;
    for (int i = 0; i < 4; i++) begin
      int tb_pos  = 31 - 4*t - i;
      int idx     = 2*int'(r[tb_pos]) + int'(r[31 - 4*s - i]);
      int tab_pos = 31 - 4*b - (3 - idx);
      if (m[3 - i]) res[tb_pos] = r[tab_pos];
    end
    return res;
  endfunction

  function automatic logic [31:0] mix(input int n);
    logic [31:0] x = 32'(n) * 32'h9E3779B1;
    return x ^ (x >> 15) ^ 32'h5A3C_96E1;
  endfunction

  task automatic run_op(input logic [31:0] pre, input int t, input int s, input int b,
                        input logic [3:0] m, input string req);
    logic [31:0] exp;
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = pre;
    @(negedge clk);
    wr_en_i = 1'b0;
    op_valid_i = 1'b1; op_tgt_i = 3'(t); op_src_i = 3'(s); op_tab_i = 3'(b); op_mask_i = m;
    @(negedge clk);
    op_valid_i = 1'b0;
    exp = (m == 4'b0) ? pre : model(pre, t, s, b, m);
    chk(req, {trap_o, creg_o}, {(m == 4'b0), exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset", {trap_o, creg_o}, 33'h0);
    rst = 1'b0;

    // R2/R3: hand case, field 0 table 4'b1000 (AND), target f1 = 1100, operand f2 = 1010
    run_op(32'h8CA0_0000, 1, 2, 0, 4'b1111, "R2 R3 and-table");
    // R4: partial mask
    run_op(32'h6F30_0000, 1, 2, 0, 4'b0101, "R4 partial mask");
    // R8: all three fields aliased
    run_op(32'h0000_0000 | 32'h0B00_0000, 1, 1, 1, 4'b1111, "R8 full alias");

    // R6/R7: zero mask traps then trap drops
    run_op(32'hDEAD_BEEF, 3, 4, 5, 4'b0000, "R6 zero mask");
    @(negedge clk);
    chk("R7 trap one cycle", {trap_o, creg_o}, {1'b0, 32'hDEAD_BEEF});

    // R9: idle holds
    repeat (3) @(negedge clk);
    chk("R9 idle hold", {1'b0, creg_o}, {1'b0, 32'hDEAD_BEEF});

    // R10: write wins over a simultaneous zero-mask op, no trap
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = 32'h1234_5678;
    op_valid_i = 1'b1; op_mask_i = 4'b0000; op_tgt_i = 3'd0;
    @(negedge clk);
    wr_en_i = 1'b0; op_valid_i = 1'b0;
    chk("R10 write priority", {trap_o, creg_o}, {1'b0, 32'h1234_5678});

    // R11/R3/R4/R5/R8: exhaustive sweep of fields and masks
    for (int t = 0; t < 8; t++)
      for (int s = 0; s < 8; s++)
        for (int b = 0; b < 8; b++)
          for (int m = 0; m < 16; m++)
            run_op(mix(((t*8 + s)*8 + b)*16 + m), t, s, b, 4'(m),
                   (m == 0) ? "R6 sweep" : "R11 R3 R4 R5 sweep");

    // R1 again: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 re-reset", {trap_o, creg_o}, 33'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule